// File: doc/BRIEF.md
# Uneven-Split Karatsuba Multiplier for 193-bit Binary Polynomials

This block multiplies two binary polynomials of degree at most 192. Each polynomial has 193 coefficients over GF(2). The result is the full, unreduced product of 385 coefficients. Coefficients are added by XOR, so there are no carries. A later stage reduces the product by a field polynomial.

The operands are not padded to 256 bits. Each one is cut into a low part of 128 bits and a high part of 65 bits. The product is then built from three sub-products, using the Karatsuba identity:
- low times low,
- high times high,
- the XOR-sums of the two parts multiplied together.

The two 128-bit sub-products use a recursive Karatsuba multiplier. It halves evenly down to an 8-bit schoolbook leaf. The 65-bit high product is cut again into one top coefficient and 64 lower coefficients. That turns it into a 64-bit Karatsuba product plus masked single-coefficient terms.

The multiplier core is purely combinational. A caller raises `start` for one cycle with both operands present. One clock edge later, `product` holds the result and `out_valid` is high for exactly that cycle. The registered product then stays unchanged until the next start.

Top module: `gf2_kara193`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `product` is all zeros and `out_valid` is 0.
- R2: `out_valid` is 1 in the cycle after a clock edge at which `start` was 1, and 0 after any edge at which `start` was 0.
- R3: After an edge with `start` high, bit i of `product` equals the coefficient of x^i in the GF(2) product of `op_a` and `op_b`, where bit i of each operand is the coefficient of x^i.
- R4: After an edge with `start` low, `product` keeps its previous value, whatever the operand inputs do.
- R5: If either operand is zero at start, the captured product is all zeros.
- R6: If one operand equals 1 (only bit 0 set) at start, the captured product equals the other operand zero-extended to 385 bits.
- R7: Bit 384 of the captured product equals `op_a[192] & op_b[192]`. If both operands have only bit 192 set, only bit 384 of the product is set.
- R8: Bit 0 of the captured product equals `op_a[0] & op_b[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the product of the present operands at this edge |
| op_a | input | 193 | First operand, bit i is the coefficient of x^i |
| op_b | input | 193 | Second operand, bit i is the coefficient of x^i |
| product | output | 385 | Registered unreduced product |
| out_valid | output | 1 | One-cycle pulse marking a freshly captured product |

## Verification
The operand patterns are chosen so that each tests one part of the split:
- **Zero:** shows that no stray term leaks in.
- **One:** shows that the low 128-bit path passes the other operand through each position unchanged.
- **Only bit 192 set:** uses the single top coefficient and the masked cross terms alone. A fault in the 2k offset of the high product shows up there and nowhere else.
- **All-ones:** drives every sub-product and the 64/1 split at once. Its product has a known alternating pattern.
- **Random operands:** catch misplaced middle-term offsets and mistakes in how the high part is zero-extended before the XOR.

Pulses sent back to back and pulses separated by idle cycles with changing operands show the difference between capturing on start and holding otherwise.

// File: rtl/gf2_kara_pkg.sv
package gf2_kara_pkg;
    // Operand width at which the recursion stops and a plain AND/XOR array is used
    localparam int KARA_LEAF_W = 8;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_FRESH = 1'b1
    } out_flag_e;
endpackage

// File: rtl/gf2_kmul.sv
// Recursive Karatsuba GF(2) polynomial multiplier, N must be a power of two times LEAF.
module gf2_kmul #(
    parameter int N    = 128,
    parameter int LEAF = gf2_kara_pkg::KARA_LEAF_W
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-2:0] p
);
    generate
        if (N <= LEAF) begin : g_leaf
            always_comb begin
                p = '0;
                for (int i = 0; i < N; i++) begin
                    for (int j = 0; j < N; j++) begin
                        p[i+j] = p[i+j] ^ (a[i] & b[j]);
                    end
                end
            end
        end else begin : g_split
            localparam int H  = N / 2;
            localparam int PW = 2 * H - 1;

            logic [H-1:0]  a_sum, b_sum;
            logic [PW-1:0] lo_p, hi_p, sum_p, mid_p;

            assign a_sum = a[N-1:H] ^ a[H-1:0];
            assign b_sum = b[N-1:H] ^ b[H-1:0];

            gf2_kmul #(.N(H), .LEAF(LEAF)) u_lo (
                .a(a[H-1:0]), .b(b[H-1:0]), .p(lo_p));
            gf2_kmul #(.N(H), .LEAF(LEAF)) u_hi (
                .a(a[N-1:H]), .b(b[N-1:H]), .p(hi_p));
            gf2_kmul #(.N(H), .LEAF(LEAF)) u_sum (
                .a(a_sum), .b(b_sum), .p(sum_p));

            assign mid_p = sum_p ^ lo_p ^ hi_p;

            always_comb begin
                p = '0;
                p[PW-1:0]     = lo_p;
                p[2*N-2:N]    = hi_p;
                p[H+PW-1:H]   = p[H+PW-1:H] ^ mid_p;
            end
        end
    endgenerate
endmodule

// File: rtl/gf2_himul.sv
// Product of two (M+1)-coefficient polynomials: an M-wide Karatsuba core plus
// single-coefficient terms contributed by the top coefficient of each operand.
module gf2_himul #(
    parameter int M    = 64,
    parameter int LEAF = gf2_kara_pkg::KARA_LEAF_W
) (
    input  logic [M:0]   a,
    input  logic [M:0]   b,
    output logic [2*M:0] p
);
    localparam int CW = 2 * M - 1;

    logic [CW-1:0] core_p;
    logic [M-1:0]  cross_p;

    gf2_kmul #(.N(M), .LEAF(LEAF)) u_core (
        .a(a[M-1:0]), .b(b[M-1:0]), .p(core_p));

    assign cross_p = ({M{a[M]}} & b[M-1:0]) ^ ({M{b[M]}} & a[M-1:0]);

    always_comb begin
        p = '0;
        p[CW-1:0]    = core_p;
        p[2*M-1:M]   = p[2*M-1:M] ^ cross_p;
        p[2*M]       = p[2*M] ^ (a[M] & b[M]);
    end
endmodule

// File: rtl/gf2_kara193.sv
// Unreduced GF(2) product of two 193-coefficient polynomials, uneven 128/65 split.
module gf2_kara193 #(
    parameter int LO_W     = 128,
    parameter int HI_SUB_W = 64,
    parameter int LEAF_W   = gf2_kara_pkg::KARA_LEAF_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [LO_W+HI_SUB_W:0]            op_a,
    input  logic [LO_W+HI_SUB_W:0]            op_b,
    output logic [2*(LO_W+HI_SUB_W+1)-2:0]    product,
    output logic                              out_valid
);
    import gf2_kara_pkg::*;

    localparam int HI_W  = HI_SUB_W + 1;
    localparam int W     = LO_W + HI_W;
    localparam int PW    = 2 * W - 1;
    localparam int LOP_W = 2 * LO_W - 1;
    localparam int HIP_W = 2 * HI_W - 1;

    typedef struct packed {
        logic [PW-1:0] prod;
        out_flag_e     flag;
    } state_t;

    state_t st_d, st_q;

    logic [LO_W-1:0]  a_fold, b_fold;
    logic [LOP_W-1:0] lo_p, sum_p, mid_p;
    logic [HIP_W-1:0] hi_p;
    logic [PW-1:0]    prod_c;

    // Middle operands: high part zero-extended to the low width before the XOR
    assign a_fold = op_a[LO_W-1:0] ^ LO_W'(op_a[W-1:LO_W]);
    assign b_fold = op_b[LO_W-1:0] ^ LO_W'(op_b[W-1:LO_W]);

    gf2_kmul #(.N(LO_W), .LEAF(LEAF_W)) u_lo_mul (
        .a(op_a[LO_W-1:0]), .b(op_b[LO_W-1:0]), .p(lo_p));
    gf2_kmul #(.N(LO_W), .LEAF(LEAF_W)) u_sum_mul (
        .a(a_fold), .b(b_fold), .p(sum_p));
    gf2_himul #(.M(HI_SUB_W), .LEAF(LEAF_W)) u_hi_mul (
        .a(op_a[W-1:LO_W]), .b(op_b[W-1:LO_W]), .p(hi_p));

    assign mid_p = sum_p ^ lo_p ^ LOP_W'(hi_p);

    always_comb begin
        prod_c = '0;
        prod_c[LOP_W-1:0]                = lo_p;
        prod_c[2*LO_W+HIP_W-1:2*LO_W]    = hi_p;
        prod_c[LO_W+LOP_W-1:LO_W]        = prod_c[LO_W+LOP_W-1:LO_W] ^ mid_p;
    end

    always_comb begin
        st_d = st_q;
        st_d.flag = start ? OUT_FRESH : OUT_IDLE;
        if (start) begin
            st_d.prod = prod_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prod: '0, flag: OUT_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign product   = st_q.prod;
    assign out_valid = (st_q.flag == OUT_FRESH);
endmodule

// File: rtl/gf2_kara193_chk.sv
module gf2_kara193_chk #(
    parameter int W = 193
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic [2*W-2:0] product,
    input logic           out_valid
);
    localparam int PW = 2 * W - 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (product == '0 && !out_valid)
                else $error("reset state not clear");
        end
    end

    assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> out_valid);
    assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !out_valid);
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(product));
    assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op_a == '0 || op_b == '0)) |=> (product == '0));
    assert_identity_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_a == W'(1)) |=> (product == PW'($past(op_b))));
    assert_identity_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_b == W'(1)) |=> (product == PW'($past(op_a))));
    assert_top_coeff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (product[PW-1] == ($past(op_a[W-1]) & $past(op_b[W-1]))));
    assert_low_coeff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (product[0] == ($past(op_a[0]) & $past(op_b[0]))));
endmodule

bind gf2_kara193 gf2_kara193_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .product(product), .out_valid(out_valid));

// File: tb/gf2_kara193_bench.sv
module gf2_kara193_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 193;
    localparam int PW = 2 * W - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [PW-1:0] product;
    logic          out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;

    logic [PW-1:0] exp_prod;
    logic          exp_vld;

    gf2_kara193 u_gf2_kara193 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .product(product), .out_valid(out_valid));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bit-serial shift-and-XOR reference
    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [PW-1:0] acc = '0;
        logic [PW-1:0] sh  = PW'(a);
        for (int i = 0; i < W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh << 1;
        end
        return acc;
    endfunction

    function automatic logic [W-1:0] rnd();
        return W'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
    endfunction

    task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural cycle model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_prod <= '0;
            exp_vld  <= 1'b0;
        end else begin
            exp_vld <= start;
            if (start) exp_prod <= ref_mul(op_a, op_b);
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            chk(out_valid == exp_vld, "R2 out_valid", PW'(out_valid), PW'(exp_vld));
            chk(product == exp_prod, "R3/R4 product", product, exp_prod);
        end
    end

    // Called at a negedge; returns at the next negedge with the result captured
    task automatic pulse(input logic [W-1:0] a, input logic [W-1:0] b);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a  = rnd();
        op_b  = rnd();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0]  r;
        logic [PW-1:0] e;
        repeat (3) @(negedge clk);
        chk(product == '0 && !out_valid, "R1 reset state", product, '0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);

        r = rnd();
        pulse('0, r);
        chk(product == '0, "R5 zero times random", product, '0);
        pulse(r, '0);
        chk(product == '0, "R5 random times zero", product, '0);

        r = rnd();
        pulse(W'(1), r);
        chk(product == PW'(r), "R6 one times random", product, PW'(r));
        pulse(r, W'(1));
        chk(product == PW'(r), "R6 random times one", product, PW'(r));

        pulse({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}});
        e = '0; e[PW-1] = 1'b1;
        chk(product == e, "R7 top-only operands", product, e);

        pulse('1, '1);
        e = '0;
        for (int i = 0; i < PW; i += 2) e[i] = 1'b1;
        chk(product == e, "R3 all-ones alternating", product, e);
        chk(product[PW-1] == 1'b1, "R7 all-ones top coeff", PW'(product[PW-1]), PW'(1));
        chk(product[0] == 1'b1, "R8 all-ones low coeff", PW'(product[0]), PW'(1));

        // Idle cycles with changing operands: held value
        e = product;
        repeat (4) begin
            op_a = rnd();
            op_b = rnd();
            @(negedge clk);
        end
        chk(product == e, "R4 hold while idle", product, e);

        // Random, with gaps
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] a = rnd();
            logic [W-1:0] b = rnd();
            pulse(a, b);
            chk(product[0] == (a[0] & b[0]), "R8 low coeff", PW'(product[0]), PW'(a[0] & b[0]));
            if (k % 3 == 0) @(negedge clk);
        end

        // Back-to-back starts
        start = 1'b1;
        for (int k = 0; k < 30; k++) begin
            op_a = rnd();
            op_b = rnd();
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);

        // Mid-run reset
        pulse(rnd(), rnd());
        #(CLK_PERIOD / 4);
        rst_n = 1'b0;
        #1;
        chk(product == '0 && !out_valid, "R1 async reset clears", product, '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule